// File: doc/BRIEF.md
# Strip-Mined Vector Multiply-Accumulate Engine

This block is a hardware sequencer that performs the update y[i] = y[i] + a * x[i] over a job of n signed-or-unsigned 32-bit integer elements held in a single-port, word-wide memory. Software (or a neighbouring controller) presents two word-aligned byte pointers, an element count and a scalar, pulses `start`, and waits for the one-cycle `done` pulse.

The job is processed in strips. At the top of every strip the engine grants a vector length equal to the smaller of its lane count and the number of elements still outstanding. It then fetches that many x words, fetches that many y words, forms the multiply-accumulate in every enabled lane, writes the y words back, steps both pointers by four bytes per element and lowers the outstanding count by the granted length. A final partial strip and an empty job run through the same loop: lanes at or above the granted length are never fetched, computed into or written, and a job of zero elements finishes without touching memory.

Top module: `vmac_strip_engine`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `mem_en` and `mem_we` are low until a job is started.
- R2: `start` is accepted only while `busy` is low; on acceptance the engine captures `x_addr`, `y_addr`, `n_elems` and `a_scalar`, and a `start` pulse while `busy` is high changes nothing in the job in progress.
- R3: Each strip opens with one grant cycle (busy high, no memory access) that sets the vector length VL to min(MVL, remaining), MVL = 4 by default; the strip then makes exactly VL x reads, VL y reads and VL writes.
- R4: After the grant cycle the strip issues VL reads (`mem_en`=1, `mem_we`=0) at byte addresses xptr+4i for i = 0..VL-1 in ascending order, then VL reads at yptr+4i, then two cycles without access, then VL writes (`mem_we`=1) at yptr+4i in ascending order.
- R5: Each written word equals (y_i + x_i * a) truncated to 32 bits, wrapping on overflow.
- R6: After the last write of a strip both pointers have advanced by 4*VL bytes and the remaining count has dropped by VL; the next grant cycle follows straight after that write.
- R7: In a partial final strip no lane at index VL or above is read or written, so the memory word just past the last y element stays unchanged.
- R8: A job with n = 0 raises `done` in the grant cycle directly after the accepting clock edge and performs no memory access.
- R9: `done` is a single-cycle pulse in the grant cycle that finds the remaining count at zero; `busy` is high from the cycle after acceptance through that cycle and low in the next.
- R10: Read data is taken from `mem_rdata` in the cycle after the read request, as a memory with one cycle of read latency delivers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job launch, taken only while idle |
| x_addr | input | AW | Byte pointer to the first x element (word aligned) |
| y_addr | input | AW | Byte pointer to the first y element (word aligned) |
| n_elems | input | NW | Number of elements in the job |
| a_scalar | input | 32 | Multiplier applied to every x element |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| mem_en | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |

## Verification
Every output is due at a fixed cycle counted from the clock edge that accepts `start`: the first grant cycle is the next cycle, the x reads fill the following VL cycles, the y reads the VL cycles after those, two quiet cycles follow, then VL write cycles, and the next grant (or the `done` pulse) comes one cycle after the last write. The bench turns each job into a per-cycle list of expected memory requests, write data, `busy` and `done`, built from the requirements and a memory snapshot, and compares the ports against that list one nanosecond after every rising edge, so each result is checked in exactly the cycle it is due. After each job it also reads the bench memory to confirm the stored results and the untouched word past the end.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GRANT,
    PH_FETCH_X,
    PH_FETCH_Y,
    PH_SETTLE,
    PH_MAC,
    PH_STORE
  } phase_t;

  // Strip length: lanes granted for the next strip.
  function automatic int unsigned strip_len(input int unsigned remaining,
                                            input int unsigned lanes);
    return (remaining < lanes) ? remaining : lanes;
  endfunction

  // 32-bit wrap-around multiply-accumulate.
  function automatic logic [31:0] mac_word(input logic [31:0] acc,
                                           input logic [31:0] xv,
                                           input logic [31:0] av);
    return acc + xv * av;
  endfunction

endpackage

// File: rtl/vmac_ctrl.sv
module vmac_ctrl
  import vmac_pkg::*;
#(
  parameter int MVL = 4,
  parameter int AW  = 12,
  parameter int NW  = 16,
  parameter int LW  = $clog2(MVL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] x_addr,
  input  logic [AW-1:0] y_addr,
  input  logic [NW-1:0] n_elems,
  output logic          busy,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          rd_fire,
  output logic          rd_to_y,
  output logic          mac_fire,
  output logic [LW-1:0] lane_idx,
  output logic [LW-1:0] vl
);

  phase_t        ph_q;
  logic [AW-1:0] xp_q, yp_q;
  logic [NW-1:0] n_q;
  logic [LW-1:0] vl_q, idx_q;

  // Named internal events
  logic          accept;
  logic          last_el;
  logic          strip_end;
  logic [LW-1:0] vl_next;
  logic [AW-1:0] byte_step;
  logic [AW-1:0] base_ptr;

  assign accept    = start && (ph_q == PH_IDLE);
  assign last_el   = ((idx_q + LW'(1)) == vl_q);
  assign strip_end = (ph_q == PH_STORE) && last_el;
  assign vl_next   = LW'(strip_len(32'(n_q), MVL));
  assign byte_step = AW'({vl_q, 2'b00});
  assign base_ptr  = (ph_q == PH_FETCH_X) ? xp_q : yp_q;

  assign busy     = (ph_q != PH_IDLE);
  assign done     = (ph_q == PH_GRANT) && (n_q == '0);
  assign mem_en   = (ph_q == PH_FETCH_X) || (ph_q == PH_FETCH_Y) || (ph_q == PH_STORE);
  assign mem_we   = (ph_q == PH_STORE);
  assign mem_addr = base_ptr + AW'({idx_q, 2'b00});
  assign rd_fire  = (ph_q == PH_FETCH_X) || (ph_q == PH_FETCH_Y);
  assign rd_to_y  = (ph_q == PH_FETCH_Y);
  assign mac_fire = (ph_q == PH_MAC);
  assign lane_idx = idx_q;
  assign vl       = vl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      xp_q  <= '0;
      yp_q  <= '0;
      n_q   <= '0;
      vl_q  <= '0;
      idx_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            xp_q <= x_addr;
            yp_q <= y_addr;
            n_q  <= n_elems;
            ph_q <= PH_GRANT;
          end
        end
        PH_GRANT: begin
          if (n_q == '0) begin
            ph_q <= PH_IDLE;
          end else begin
            vl_q  <= vl_next;
            idx_q <= '0;
            ph_q  <= PH_FETCH_X;
          end
        end
        PH_FETCH_X: begin
          if (last_el) begin
            idx_q <= '0;
            ph_q  <= PH_FETCH_Y;
          end else begin
            idx_q <= idx_q + LW'(1);
          end
        end
        PH_FETCH_Y: begin
          if (last_el) begin
            idx_q <= '0;
            ph_q  <= PH_SETTLE;
          end else begin
            idx_q <= idx_q + LW'(1);
          end
        end
        PH_SETTLE: ph_q <= PH_MAC;
        PH_MAC:    ph_q <= PH_STORE;
        PH_STORE: begin
          if (last_el) begin
            idx_q <= '0;
            xp_q  <= xp_q + byte_step;
            yp_q  <= yp_q + byte_step;
            n_q   <= n_q - NW'(vl_q);
            ph_q  <= PH_GRANT;
          end else begin
            idx_q <= idx_q + LW'(1);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en); // R1

  AST_DONE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_en); // R8

  AST_LANE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (idx_q < vl_q)); // R7

  AST_VL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ((vl_q != '0) && (vl_q <= LW'(MVL)))); // R3

  AST_COUNT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    strip_end |=> (n_q < $past(n_q))); // R6

  AST_GRANT_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    strip_end |=> (busy && !mem_en)); // R6

endmodule

// File: rtl/vmac_lanes.sv
module vmac_lanes
  import vmac_pkg::*;
#(
  parameter int MVL = 4,
  parameter int LW  = $clog2(MVL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_load,
  input  logic [31:0]   a_in,
  input  logic          rd_fire,
  input  logic          rd_to_y,
  input  logic [LW-1:0] lane_idx,
  input  logic [31:0]   rdata,
  input  logic          mac_fire,
  input  logic [LW-1:0] vl,
  output logic [31:0]   wdata
);

  logic [31:0]       a_q;
  logic              cap_vld_q;
  logic              cap_y_q;
  logic [LW-1:0]     cap_lane_q;
  logic [MVL*32-1:0] y_flat;

  // Read request of this cycle returns data next cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q        <= '0;
      cap_vld_q  <= 1'b0;
      cap_y_q    <= 1'b0;
      cap_lane_q <= '0;
    end else begin
      if (a_load) a_q <= a_in;
      cap_vld_q  <= rd_fire;
      cap_y_q    <= rd_to_y;
      cap_lane_q <= lane_idx;
    end
  end

  for (genvar g = 0; g < MVL; g++) begin : g_lane
    logic [31:0] xr, yr;
    logic        hit;
    logic        enabled;

    assign hit     = cap_vld_q && (cap_lane_q == LW'(g));
    assign enabled = (LW'(g) < vl);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        xr <= '0;
        yr <= '0;
      end else begin
        if (hit && !cap_y_q) xr <= rdata;
        if (hit && cap_y_q) yr <= rdata;
        else if (mac_fire && enabled) yr <= mac_word(yr, xr, a_q);
      end
    end

    assign y_flat[g*32 +: 32] = yr;

    AST_NO_CAPTURE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> enabled); // R7
  end

  always_comb begin
    wdata = '0;
    for (int i = 0; i < MVL; i++) begin
      if (lane_idx == LW'(i)) wdata = y_flat[i*32 +: 32];
    end
  end

  AST_SETTLED_BEFORE_MAC: assert property (@(posedge clk) disable iff (!rst_n)
    mac_fire |-> !cap_vld_q); // R10

endmodule

// File: rtl/vmac_strip_engine.sv
module vmac_strip_engine #(
  parameter int MVL = 4,
  parameter int AW  = 12,
  parameter int NW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] x_addr,
  input  logic [AW-1:0] y_addr,
  input  logic [NW-1:0] n_elems,
  input  logic [31:0]   a_scalar,
  output logic          busy,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);

  localparam int LW = $clog2(MVL + 1);

  logic          rd_fire, rd_to_y, mac_fire;
  logic [LW-1:0] lane_idx, vl;
  logic          a_load;

  assign a_load = start && !busy;

  vmac_ctrl #(.MVL(MVL), .AW(AW), .NW(NW), .LW(LW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .x_addr   (x_addr),
    .y_addr   (y_addr),
    .n_elems  (n_elems),
    .busy     (busy),
    .done     (done),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .rd_fire  (rd_fire),
    .rd_to_y  (rd_to_y),
    .mac_fire (mac_fire),
    .lane_idx (lane_idx),
    .vl       (vl)
  );

  vmac_lanes #(.MVL(MVL), .LW(LW)) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_load   (a_load),
    .a_in     (a_scalar),
    .rd_fire  (rd_fire),
    .rd_to_y  (rd_to_y),
    .lane_idx (lane_idx),
    .rdata    (mem_rdata),
    .mac_fire (mac_fire),
    .vl       (vl),
    .wdata    (mem_wdata)
  );

  AST_WRITE_IS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en); // R4

endmodule

// File: tb/vmac_strip_engine_bench.sv
module vmac_strip_engine_bench;
  localparam int MVL = 4;
  localparam int AW  = 12;
  localparam int NW  = 16;
  localparam int WORDS = 1 << (AW - 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] x_addr = '0, y_addr = '0;
  logic [NW-1:0] n_elems = '0;
  logic [31:0]   a_scalar = '0;
  logic          busy, done, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;

  int total = 0;
  int bad = 0;

  logic [31:0] mem [WORDS];

  always #2 clk = ~clk;

  vmac_strip_engine #(.MVL(MVL), .AW(AW), .NW(NW)) u_vmac_strip_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .x_addr(x_addr), .y_addr(y_addr),
    .n_elems(n_elems), .a_scalar(a_scalar), .busy(busy), .done(done),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory with one cycle of read latency (R10)
  always @(posedge clk) begin
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[AW-1:2]];
    if (mem_en && mem_we) mem[mem_addr[AW-1:2]] <= mem_wdata;
  end

  // Expected per-cycle trace
  bit          q_en[$], q_we[$], q_done[$], q_busy[$];
  int          q_addr[$];
  logic [31:0] q_data[$];
  string       q_tag[$];

  task automatic push(bit en, bit we, int addr, logic [31:0] d, bit dn, bit bs, string t);
    q_en.push_back(en); q_we.push_back(we); q_addr.push_back(addr);
    q_data.push_back(d); q_done.push_back(dn); q_busy.push_back(bs); q_tag.push_back(t);
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic run_job(int xb, int yb, int n, logic [31:0] a, int inject);
    logic [31:0] ye[$];
    logic [31:0] tail;
    int rem, off, vl;
    ye.delete();
    for (int i = 0; i < n; i++)
      ye.push_back(mem[(yb >> 2) + i] + mem[(xb >> 2) + i] * a);
    tail = mem[(yb >> 2) + n];
    rem = n;
    off = 0;
    forever begin
      push(0, 0, 0, 0, rem == 0, 1, (rem == 0) ? ((n == 0) ? "R8" : "R9")
                                                 : ((off == 0) ? "R2" : "R6"));
      if (rem == 0) break;
      vl = (rem < MVL) ? rem : MVL;
      for (int i = 0; i < vl; i++) push(1, 0, xb + 4 * (off + i), 0, 0, 1, (vl < MVL) ? "R7" : "R4");
      for (int i = 0; i < vl; i++) push(1, 0, yb + 4 * (off + i), 0, 0, 1, (vl < MVL) ? "R7" : "R3");
      push(0, 0, 0, 0, 0, 1, "R10");
      push(0, 0, 0, 0, 0, 1, "R10");
      for (int i = 0; i < vl; i++) push(1, 1, yb + 4 * (off + i), ye[off + i], 0, 1, "R5");
      off += vl;
      rem -= vl;
    end
    push(0, 0, 0, 0, 0, 0, "R9");

    @(negedge clk);
    start = 1'b1;
    x_addr = AW'(xb);
    y_addr = AW'(yb);
    n_elems = NW'(n);
    a_scalar = a;
    @(posedge clk);
    #1;
    start = 1'b0;
    for (int c = 0; c < q_en.size(); c++) begin
      if (c == inject) begin
        // R2: start while busy must be ignored
        start = 1'b1;
        x_addr = AW'(12'h3F0);
        y_addr = AW'(12'h3F8);
        n_elems = NW'(3);
        a_scalar = 32'd5;
      end
      check(mem_en == q_en[c], q_tag[c], "mem_en", 32'(mem_en), 32'(q_en[c]));
      check(done == q_done[c], q_tag[c], "done", 32'(done), 32'(q_done[c]));
      check(busy == q_busy[c], q_tag[c], "busy", 32'(busy), 32'(q_busy[c]));
      if (q_en[c]) begin
        check(mem_we == q_we[c], q_tag[c], "mem_we", 32'(mem_we), 32'(q_we[c]));
        check(32'(mem_addr) == 32'(q_addr[c]), q_tag[c], "mem_addr", 32'(mem_addr), 32'(q_addr[c]));
        if (q_we[c])
          check(mem_wdata == q_data[c], q_tag[c], "mem_wdata", mem_wdata, q_data[c]);
      end
      @(posedge clk);
      #1;
      start = 1'b0;
    end
    q_en.delete(); q_we.delete(); q_addr.delete(); q_data.delete();
    q_done.delete(); q_busy.delete(); q_tag.delete();

    for (int i = 0; i < n; i++)
      check(mem[(yb >> 2) + i] == ye[i], (inject >= 0) ? "R2" : "R5", "stored y",
            mem[(yb >> 2) + i], ye[i]);
    check(mem[(yb >> 2) + n] == tail, (n == 0) ? "R8" : "R7", "word past end",
          mem[(yb >> 2) + n], tail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R9 actual=no-finish expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = (32'(i) * 32'h9E37_79B9) ^ 32'h0000_5A5A;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !done && !mem_en && !mem_we, "R1", "outputs in reset",
          {28'd0, busy, done, mem_en, mem_we}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(!busy && !done && !mem_en && !mem_we, "R1", "outputs after reset",
          {28'd0, busy, done, mem_en, mem_we}, 32'd0);

    run_job(32'h010, 32'h200, 10, 32'd3, -1);            // R7 partial last strip
    run_job(32'h020, 32'h800, 0, 32'd9, -1);             // R8 empty job
    run_job(32'h100, 32'h300, 4, 32'hFFFF_FFFF, -1);     // R5 wrap, exact strip
    run_job(32'h040, 32'h500, 1, 32'd7, -1);             // R3 single lane
    run_job(32'h080, 32'h600, 7, 32'd11, 5);             // R2 start ignored when busy
    run_job(32'h0C0, 32'h700, 9, 32'h7FFF_FFFD, -1);     // R6 three strips, overflow

    repeat (2) @(posedge clk);
    #1;
    check(!busy && !mem_en, "R9", "idle after jobs", {30'd0, busy, mem_en}, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule